// File: doc/BRIEF.md
# Planar Bitplane Pixel Fetcher

This block turns byte slots of a 640 by 400, eight-colour planar frame into pixels. Each slot is given as a line number and a byte column within that line. For each slot the block computes a scrolled byte address and issues three reads: one to the blue plane, one to the red plane and one to the green plane of an external video memory. It then recombines the returned bytes bit by bit into eight 3-bit colour indices, and maps every index through an eight-entry palette supplied on a port. The result is eight palette words per slot, valid on a strobe at a fixed latency.

The scroll offset comes from one of two registers, chosen by the page select. It is doubled and wraps inside a 32 KiB plane. The page select and the block select move the three planes to other regions of the memory. A per-plane enable turns off any plane: that plane is not read and contributes zero bits. Slots may arrive on every cycle. The external memory is expected to return data one clock after an address is presented.

Top module: `bitplane_pixel_fetch`

## Requirements
- R1: While reset is asserted, and for the cycles after release until the first slot, `rd_o` is 3'b000 and `pix_valid_o` is 0.
- R2: The unscrolled byte position is line × 80 + column. The in-plane address is (position + 2 × (scroll & 0x3FFF)) mod 0x8000. Scroll bits above bit 13 have no effect.
- R3: With page 0 the scroll comes from `scroll_pg0_i`, and the blue, red and green planes start at 0x00000, 0x08000 and 0x10000. With page 1 the scroll comes from `scroll_pg1_i`, and the planes start at 0x18000, 0x20000 and 0x28000.
- R4: A block select of 1 adds 0x18000 to all three plane addresses, on top of the page offset.
- R5: Pixel k (k = 0 to 7, output bits [k*PAL_W +: PAL_W], pixel 0 leftmost) uses bit 7−k of each plane byte. Its index is {green bit, red bit, blue bit}.
- R6: Enable bit 0 gates blue, bit 1 gates red and bit 2 gates green. A disabled plane gets no read strobe in `rd_o` (same bit order), and its bits read as zero whatever the memory returns.
- R7: Each index i selects palette entry i, which is `palette_i[i*PAL_W +: PAL_W]`.
- R8: Addresses and `rd_o` appear in the cycle after the slot is sampled. Pixels and `pix_valid_o` appear two cycles after that. Slots on consecutive cycles yield groups on consecutive cycles.
- R9: A cycle without a slot produces no read strobe. Two cycles later it produces no valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_i | input | 1 | Fetch request for one byte slot |
| line_i | input | 9 | Display line, 0..399 |
| col_i | input | 7 | Byte column, 0..79 |
| scroll_pg0_i | input | 16 | Scroll offset for page 0 |
| scroll_pg1_i | input | 16 | Scroll offset for page 1 |
| page_i | input | 1 | Displayed page |
| block_i | input | 1 | Displayed block |
| plane_en_i | input | 3 | Plane enables {g,r,b} |
| palette_i | input | 64 | Eight palette words |
| rd_o | output | 3 | Read strobes {g,r,b} |
| addr_b_o | output | 19 | Blue plane address |
| addr_r_o | output | 19 | Red plane address |
| addr_g_o | output | 19 | Green plane address |
| data_b_i | input | 8 | Blue byte, one cycle after address |
| data_r_i | input | 8 | Red byte |
| data_g_i | input | 8 | Green byte |
| pix_o | output | 64 | Eight palette words, pixel 0 in low bits |
| pix_valid_o | output | 1 | Pixel group valid |

## Verification
The hardest case to reach is a plane that is disabled while the memory still returns nonzero bytes for it. The bench's memory model answers every address with a nonzero, address-dependent pattern, whether or not a read strobe was raised, so any leak of a masked plane changes a pixel. The second hard case is the scroll wrap at the bottom of a plane. Vectors at the last line and column, with the largest offset and with the ignored high offset bits set, push the sum past the 32 KiB boundary. A burst of back-to-back slots checks that the enable pipeline stays aligned with the data it gates.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  localparam int NPLANE = 3;
  localparam int NPIX   = 8;
  typedef logic [NPLANE-1:0] pix_idx_t;
endpackage

// File: rtl/bpf_addr_gen.sv
module bpf_addr_gen #(
  parameter int LINE_W   = 9,
  parameter int COL_W    = 7,
  parameter int OFF_W    = 16,
  parameter int SCROLL_W = 14,
  parameter int PLANE_AW = 15,
  parameter int BPL      = 80
) (
  input  logic [LINE_W-1:0]   line_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic                page_i,
  input  logic                block_i,
  output logic [PLANE_AW+3:0] addr_o [3]
);
  localparam int AW = PLANE_AW + 4;
  logic [AW-1:0]       base, sum;
  logic [PLANE_AW-1:0] inplane;
  logic [3:0]          bank;

  always_comb begin
    base    = AW'(line_i) * AW'(BPL) + AW'(col_i);
    sum     = base + AW'({off_i[SCROLL_W-1:0], 1'b0});
    inplane = sum[PLANE_AW-1:0];
    bank    = (page_i ? 4'd3 : 4'd0) + (block_i ? 4'd3 : 4'd0);
  end

  for (genvar p = 0; p < 3; p++) begin : g_plane
    assign addr_o[p] = {bank + 4'(p), inplane};
  end
endmodule

// File: rtl/bpf_slicer.sv
module bpf_slicer
  import bpf_pkg::*;
(
  input  logic [7:0] b_i,
  input  logic [7:0] r_i,
  input  logic [7:0] g_i,
  output pix_idx_t   idx_o [NPIX]
);
  for (genvar k = 0; k < NPIX; k++) begin : g_pix
    assign idx_o[k] = {g_i[NPIX-1-k], r_i[NPIX-1-k], b_i[NPIX-1-k]};
  end
endmodule

// File: rtl/bpf_palette.sv
module bpf_palette
  import bpf_pkg::*;
#(
  parameter int PAL_W = 8
) (
  input  logic [8*PAL_W-1:0]    palette_i,
  input  pix_idx_t              idx_i [NPIX],
  output logic [NPIX*PAL_W-1:0] pix_o
);
  for (genvar k = 0; k < NPIX; k++) begin : g_lut
    assign pix_o[k*PAL_W +: PAL_W] = palette_i[idx_i[k]*PAL_W +: PAL_W];
  end
endmodule

// File: rtl/bitplane_pixel_fetch.sv
module bitplane_pixel_fetch
  import bpf_pkg::*;
#(
  parameter int LINE_W   = 9,
  parameter int COL_W    = 7,
  parameter int OFF_W    = 16,
  parameter int SCROLL_W = 14,
  parameter int PLANE_AW = 15,
  parameter int BPL      = 80,
  parameter int PAL_W    = 8,
  localparam int AW      = PLANE_AW + 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_i,
  input  logic [LINE_W-1:0]     line_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic [OFF_W-1:0]      scroll_pg0_i,
  input  logic [OFF_W-1:0]      scroll_pg1_i,
  input  logic                  page_i,
  input  logic                  block_i,
  input  logic [2:0]            plane_en_i,
  input  logic [8*PAL_W-1:0]    palette_i,
  output logic [2:0]            rd_o,
  output logic [AW-1:0]         addr_b_o,
  output logic [AW-1:0]         addr_r_o,
  output logic [AW-1:0]         addr_g_o,
  input  logic [7:0]            data_b_i,
  input  logic [7:0]            data_r_i,
  input  logic [7:0]            data_g_i,
  output logic [NPIX*PAL_W-1:0] pix_o,
  output logic                  pix_valid_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // stage 1: address generation
  logic [OFF_W-1:0] off_sel;
  logic [AW-1:0]    addr_w [3];
  assign off_sel = page_i ? scroll_pg1_i : scroll_pg0_i;

  bpf_addr_gen #(
    .LINE_W(LINE_W), .COL_W(COL_W), .OFF_W(OFF_W),
    .SCROLL_W(SCROLL_W), .PLANE_AW(PLANE_AW), .BPL(BPL)
  ) u_addr (
    .line_i(line_i), .col_i(col_i), .off_i(off_sel),
    .page_i(page_i), .block_i(block_i), .addr_o(addr_w)
  );

  logic [2:0]            rd_d, rd_q, mask_q;
  logic                  v1_q, v2_q, vout_q;
  logic [AW-1:0]         ab_q, ar_q, ag_q;
  logic [7:0]            gb, gr, gg;
  pix_idx_t              idx [NPIX];
  logic [NPIX*PAL_W-1:0] pix_d, pix_q;

  always_comb begin
    rd_d = slot_i ? plane_en_i : 3'b000;
    gb   = data_b_i & {8{mask_q[0]}};
    gr   = data_r_i & {8{mask_q[1]}};
    gg   = data_g_i & {8{mask_q[2]}};
  end

  bpf_slicer u_slice (.b_i(gb), .r_i(gr), .g_i(gg), .idx_o(idx));
  bpf_palette #(.PAL_W(PAL_W)) u_pal (.palette_i(palette_i), .idx_i(idx), .pix_o(pix_d));

  // control registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_q   <= 3'b000;
      mask_q <= 3'b000;
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      vout_q <= 1'b0;
    end else begin
      rd_q   <= rd_d;
      mask_q <= rd_q;
      v1_q   <= slot_i;
      v2_q   <= v1_q;
      vout_q <= v2_q;
    end
  end

  // data registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ab_q  <= '0;
      ar_q  <= '0;
      ag_q  <= '0;
      pix_q <= '0;
    end else begin
      if (slot_i) begin
        ab_q <= addr_w[0];
        ar_q <= addr_w[1];
        ag_q <= addr_w[2];
      end
      if (v2_q) pix_q <= pix_d;
    end
  end

  assign rd_o        = rd_q;
  assign addr_b_o    = ab_q;
  assign addr_r_o    = ar_q;
  assign addr_g_o    = ag_q;
  assign pix_o       = pix_q;
  assign pix_valid_o = vout_q;
endmodule

// File: rtl/bpf_checker.sv
module bpf_checker #(
  parameter int PLANE_AW = 15,
  localparam int AW      = PLANE_AW + 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slot_i,
  input logic          page_i,
  input logic          block_i,
  input logic [2:0]    plane_en_i,
  input logic [2:0]    rd_o,
  input logic [AW-1:0] addr_b_o,
  input logic [AW-1:0] addr_r_o,
  input logic          pix_valid_o
);
  localparam logic [AW-1:0] SPAN = AW'(1) << PLANE_AW;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (rd_o == 3'b000 && !pix_valid_o));

  a_r9_rd_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o != 3'b000) |-> $past(slot_i));

  a_r8_valid_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> $past(slot_i, 3));

  a_r6_masked_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o != 3'b000) |-> ((rd_o & ~$past(plane_en_i)) == 3'b000));

  a_r3_plane_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o[0] && rd_o[1] |-> (addr_r_o == addr_b_o + SPAN));

  a_r4_block_region: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o[0] && $past(block_i)) |-> (addr_b_o >= 3 * SPAN));

  a_r3_page0_region: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o[0] && !$past(block_i) && !$past(page_i)) |-> (addr_b_o < SPAN));
endmodule

bind bitplane_pixel_fetch bpf_checker #(.PLANE_AW(PLANE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .page_i(page_i),
  .block_i(block_i), .plane_en_i(plane_en_i), .rd_o(rd_o),
  .addr_b_o(addr_b_o), .addr_r_o(addr_r_o), .pix_valid_o(pix_valid_o)
);

// File: tb/sim_bitplane_pixel_fetch.sv
module sim_bitplane_pixel_fetch;
  localparam int PERIOD = 10;
  localparam int PW = 8;

  logic        clk = 1'b0;
  logic        rst_n, slot, page, blk;
  logic [8:0]  line;
  logic [6:0]  col;
  logic [15:0] o0, o1;
  logic [2:0]  msk, rd;
  logic [63:0] pal, pix;
  logic [18:0] ab, ar, ag;
  logic [7:0]  db, dr, dg;
  logic        pv;
  int errors = 0, checks = 0;

  always #(PERIOD/2) clk = ~clk;

  bitplane_pixel_fetch u0 (
    .clk(clk), .rst_n(rst_n), .slot_i(slot), .line_i(line), .col_i(col),
    .scroll_pg0_i(o0), .scroll_pg1_i(o1), .page_i(page), .block_i(blk),
    .plane_en_i(msk), .palette_i(pal), .rd_o(rd), .addr_b_o(ab),
    .addr_r_o(ar), .addr_g_o(ag), .data_b_i(db), .data_r_i(dr),
    .data_g_i(dg), .pix_o(pix), .pix_valid_o(pv)
  );

  function automatic logic [7:0] memf(logic [18:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ {5'b10100, a[18:16]};
  endfunction

  // memory with one cycle of read latency, answers every address
  always_ff @(posedge clk) begin
    db <= memf(ab);
    dr <= memf(ar);
    dg <= memf(ag);
  end

  function automatic logic [63:0] exp_pix(logic [18:0] a, logic [2:0] m);
    logic [7:0] b, r, g;
    logic [63:0] res;
    b = memf(a) & {8{m[0]}};
    r = memf(a + 19'h08000) & {8{m[1]}};
    g = memf(a + 19'h10000) & {8{m[2]}};
    for (int k = 0; k < 8; k++)
      res[k*PW +: PW] = pal[{g[7-k], r[7-k], b[7-k]}*PW +: PW];
    return res;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [8:0]  ln;
    logic [6:0]  cl;
    logic [15:0] s0;
    logic [15:0] s1;
    logic        pg;
    logic        bk;
    logic [2:0]  m;
    logic [18:0] eb;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{9'd0,   7'd0,  16'h0000, 16'h0000, 1'b0, 1'b0, 3'b111, 19'h00000},
    '{9'd1,   7'd5,  16'h0010, 16'h0000, 1'b0, 1'b0, 3'b111, 19'h00075},
    '{9'd399, 7'd79, 16'h0001, 16'h0000, 1'b0, 1'b0, 3'b111, 19'h07D01},
    '{9'd399, 7'd79, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 3'b101, 19'h07CFD},
    '{9'd2,   7'd0,  16'h1234, 16'h0008, 1'b1, 1'b0, 3'b111, 19'h180B0},
    '{9'd0,   7'd1,  16'h0000, 16'h0000, 1'b0, 1'b1, 3'b111, 19'h18001},
    '{9'd0,   7'd0,  16'h0000, 16'h4000, 1'b1, 1'b1, 3'b110, 19'h30000},
    '{9'd10,  7'd3,  16'h0000, 16'h0000, 1'b0, 1'b0, 3'b010, 19'h00323},
    '{9'd200, 7'd40, 16'h0100, 16'h0000, 1'b0, 1'b0, 3'b000, 19'h040A8}
  };

  task automatic drive(vec_t v);
    line = v.ln; col = v.cl; o0 = v.s0; o1 = v.s1;
    page = v.pg; blk = v.bk; msk = v.m; slot = 1'b1;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) pal[i*PW +: PW] = 8'h0F + 8'h11 * 8'(i);
    rst_n = 1'b0; slot = 1'b0; line = '0; col = '0; o0 = '0; o1 = '0;
    page = 1'b0; blk = 1'b0; msk = 3'b111;
    repeat (3) @(negedge clk);
    check("R1 rd in reset", 64'(rd), 64'h0);
    check("R1 valid in reset", 64'(pv), 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid after release", 64'(pv), 64'h0);

    // table walk: one isolated slot per vector
    foreach (VECS[i]) begin
      drive(VECS[i]);
      @(negedge clk);
      slot = 1'b0;
      check("R2 R3 R4 blue addr", 64'(ab), 64'(VECS[i].eb));
      check("R3 red addr", 64'(ar), 64'(VECS[i].eb + 19'h08000));
      check("R3 green addr", 64'(ag), 64'(VECS[i].eb + 19'h10000));
      check("R6 read strobes", 64'(rd), 64'(VECS[i].m));
      check("R9 no early valid", 64'(pv), 64'h0);
      @(negedge clk);
      check("R9 no read without slot", 64'(rd), 64'h0);
      @(negedge clk);
      check("R8 valid latency", 64'(pv), 64'h1);
      check("R5 R6 R7 pixels", pix, exp_pix(VECS[i].eb, VECS[i].m));
      @(negedge clk);
      check("R9 valid drops", 64'(pv), 64'h0);
    end

    // back-to-back slots with changing mask
    for (int j = 0; j < 3; j++) begin
      drive(VECS[j + 1]);
      msk = 3'(3'b001 << j);
      @(negedge clk);
    end
    slot = 1'b0;
    check("R8 burst first valid", 64'(pv), 64'h1);
    check("R8 burst pix0", pix, exp_pix(VECS[1].eb, 3'b001));
    @(negedge clk);
    check("R8 burst second valid", 64'(pv), 64'h1);
    check("R6 burst pix1", pix, exp_pix(VECS[2].eb, 3'b010));
    @(negedge clk);
    check("R8 burst third valid", 64'(pv), 64'h1);
    check("R6 burst pix2", pix, exp_pix(VECS[3].eb, 3'b100));
    @(negedge clk);
    check("R9 burst ends", 64'(pv), 64'h0);

    // reset mid-stream clears the strobes
    drive(VECS[0]);
    @(negedge clk);
    rst_n = 1'b0;
    slot = 1'b0;
    #1;
    check("R1 async clear rd", 64'(rd), 64'h0);
    check("R1 async clear valid", 64'(pv), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 quiet after reset", 64'(pv), 64'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule